// File: doc/BRIEF.md
# Scratch Register and FIFO Fill-Level Window

This block is a register slice on the host bus of a serial channel. It owns one bus address. That address acts in one of two ways. It can be a general-purpose 8-bit scratch location that the host may read and write. It can also be a read window onto the receive and transmit FIFO fill counts. The FIFO counts arrive as plain inputs from the FIFO logic.

A swap-enable bit chooses between the two roles. The bit lives in a feature-control register elsewhere and comes in as an input.

- When swap is off, the address behaves as scratch storage.
- When swap is on, host writes go to a small mode register and leave the scratch storage alone. Two bits of the mode register then select what reads return: the receive count, the transmit count, or the two in turn.

One more bit of the mode register sets the polarity of the automatic half-duplex direction line. That bit is exported as a level for the line driver.

Top module: `scratch_level_win`

## Requirements
- R1: With `swap_en` low, a write strobe to the owned address stores `wdata` in the scratch register, and reads return that stored value.
- R2: After reset, the scratch register reads 0xFF, the mode register is 0, `dir_pol` is 0, and the alternating phase points at receive.
- R3: The `sleep` input leaves the scratch contents unchanged.
- R4: With `swap_en` high, a write to the owned address updates the mode register from `wdata[3:0]` and leaves the scratch register unchanged.
- R5: With `swap_en` high, the read source depends on the mode bits:
  - `mode[0]`=0 returns the receive level.
  - `mode[1:0]`=01 returns the transmit level.
  - `mode[1:0]`=11 alternates between the two.
- R6: In alternating mode, the first read after a mode write returns the receive level, and each later completed read flips to the other source.
- R7: Every mode write returns the phase to receive, even when the value written equals the stored one.
- R8: The phase changes only on a read strobe to the owned address. Idle cycles and reads of other addresses leave it unchanged.
- R9: `dir_pol` follows mode bit 3. Mode bit 2 is stored but has no effect.
- R10: Fill levels are 7 bits wide (0 to 64) and are zero-extended onto the 8-bit read bus.
- R11: With `swap_en` low, reads return the scratch value whatever the mode holds. The mode bits keep their value and apply again once swap is re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Low-power state indication |
| swap_en | input | 1 | Role select from the feature-control register |
| addr | input | 3 | Host register address |
| wr | input | 1 | Host write strobe |
| rd | input | 1 | Host read strobe; the read completes at the clock edge |
| wdata | input | 8 | Host write data |
| rx_level | input | 7 | Receive FIFO fill count |
| tx_level | input | 7 | Transmit FIFO fill count |
| rdata | output | 8 | Read data for the owned address |
| dir_pol | output | 1 | Half-duplex direction polarity: 1 drives the line high while transmitting |

## Verification
The alternating phase is the only hidden state that changes on reads. If it is wrong, the very next read at the owned address returns the transmit count where the receive count was due, or the reverse. A stale or wrongly cleared mode register shows up the same way: the next read returns the wrong source, or `dir_pol` shows the wrong polarity. A scratch register disturbed by mode writes or by sleep is exposed as soon as swap is turned off and the address is read.

// File: rtl/scratch_level_win.sv
module scratch_level_win #(
  parameter int DW       = 8,
  parameter int LW       = 7,
  parameter int AW       = 3,
  parameter logic [AW-1:0] MY_ADDR = 3'd7,
  parameter logic [DW-1:0] SCR_INIT = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          swap_en,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  output logic [DW-1:0] rdata,
  output logic          dir_pol
);
  localparam int MW = 4;

  logic [DW-1:0] scratch;
  logic [MW-1:0] mode;
  logic          phase_tx;
  logic          hit, wr_hit, rd_hit, alt_mode, sel_tx;
  logic [DW-1:0] rx_ext, tx_ext;

  assign hit      = (addr == MY_ADDR);
  assign wr_hit   = hit && wr;
  assign rd_hit   = hit && rd;
  assign alt_mode = (mode[1:0] == 2'b11);
  assign rx_ext   = {{(DW-LW){1'b0}}, rx_level};
  assign tx_ext   = {{(DW-LW){1'b0}}, tx_level};
  assign sel_tx   = mode[0] && (!mode[1] || phase_tx);
  assign rdata    = !swap_en ? scratch : (sel_tx ? tx_ext : rx_ext);
  assign dir_pol  = mode[3];

  always_ff @(posedge clk) begin
    if (!rst_n) scratch <= SCR_INIT;
    else if (wr_hit && !swap_en) scratch <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= '0;
    else if (wr_hit && swap_en) mode <= wdata[MW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_tx <= 1'b0;
    else if (wr_hit && swap_en) phase_tx <= 1'b0;
    else if (rd_hit && swap_en && alt_mode) phase_tx <= !phase_tx;
  end

  assert_swap_write_keeps_scratch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && swap_en) |=> $stable(scratch));

  assert_sleep_keeps_scratch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !wr_hit) |=> $stable(scratch));

  assert_mode_write_restarts_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && swap_en) |=> !phase_tx);

  assert_phase_only_on_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hit && !wr_hit) |=> $stable(phase_tx));

  assert_alt_read_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !wr_hit && swap_en && alt_mode) |=> (phase_tx != $past(phase_tx)));

  assert_level_zero_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en |-> (rdata[DW-1:LW] == '0));
endmodule

// File: tb/sim_scratch_level_win.sv
module sim_scratch_level_win;
  logic clk = 1'b0, rst_n = 1'b0, sleep = 1'b0, swap_en = 1'b0;
  logic [2:0] addr = 3'd7;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [6:0] rx_level = '0, tx_level = '0;
  logic [7:0] rdata;
  logic dir_pol;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  scratch_level_win u0 (.clk(clk), .rst_n(rst_n), .sleep(sleep), .swap_en(swap_en),
    .addr(addr), .wr(wr), .rd(rd), .wdata(wdata), .rx_level(rx_level),
    .tx_level(tx_level), .rdata(rdata), .dir_pol(dir_pol));

  // op: 0 write, 1 read and compare rdata, 2 compare dir_pol with exp[0]
  localparam int NV = 24;
  localparam logic [32:0] VEC [NV] = '{
    {2'd0,1'b0,8'h5A,7'd10,7'd20,8'h00},
    {2'd1,1'b0,8'h00,7'd10,7'd20,8'h5A},
    {2'd0,1'b1,8'h00,7'd10,7'd20,8'h00},
    {2'd1,1'b1,8'h00,7'd10,7'd20,8'h0A},
    {2'd1,1'b1,8'h00,7'd10,7'd20,8'h0A},
    {2'd0,1'b1,8'h01,7'd10,7'd20,8'h00},
    {2'd1,1'b1,8'h00,7'd10,7'd20,8'h14},
    {2'd1,1'b1,8'h00,7'd10,7'd20,8'h14},
    {2'd0,1'b1,8'h03,7'd10,7'd20,8'h00},
    {2'd1,1'b1,8'h00,7'd10,7'd20,8'h0A},
    {2'd1,1'b1,8'h00,7'd10,7'd20,8'h14},
    {2'd1,1'b1,8'h00,7'd10,7'd20,8'h0A},
    {2'd1,1'b0,8'h00,7'd10,7'd20,8'h5A},
    {2'd1,1'b1,8'h00,7'd10,7'd20,8'h14},
    {2'd0,1'b1,8'h03,7'd10,7'd20,8'h00},
    {2'd1,1'b1,8'h00,7'd10,7'd20,8'h0A},
    {2'd0,1'b1,8'h0B,7'd10,7'd20,8'h00},
    {2'd2,1'b1,8'h00,7'd10,7'd20,8'h01},
    {2'd1,1'b1,8'h00,7'd10,7'd20,8'h0A},
    {2'd0,1'b1,8'h07,7'd10,7'd20,8'h00},
    {2'd2,1'b1,8'h00,7'd10,7'd20,8'h00},
    {2'd1,1'b1,8'h00,7'd64,7'd20,8'h40},
    {2'd1,1'b1,8'h00,7'd64,7'd33,8'h21},
    {2'd1,1'b0,8'h00,7'd64,7'd33,8'h5A}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); addr = 3'd7; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_read(input string req, input logic [7:0] exp);
    @(negedge clk); addr = 3'd7; #1;
    check(req, rdata, exp);
    rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R2 scratch reset", rdata, 8'hFF);
    check("R2 dir reset", {7'd0, dir_pol}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      swap_en  = VEC[i][30];
      rx_level = VEC[i][21:15];
      tx_level = VEC[i][14:8];
      case (VEC[i][32:31])
        2'd0: do_write(VEC[i][29:22]);
        2'd1: do_read("R1/R4/R5/R6/R7/R10/R11 vector", VEC[i][7:0]);
        default: begin #1; check("R9 dir_pol", {7'd0, dir_pol}, VEC[i][7:0]); end
      endcase
    end

    // R8: read of another address and idle cycles keep the phase (next is TX)
    @(negedge clk); swap_en = 1'b1; rx_level = 7'd10; tx_level = 7'd20;
    do_write(8'h03);
    do_read("R6 first rx", 8'h0A);
    @(negedge clk); addr = 3'd2; rd = 1'b1;
    @(negedge clk); rd = 1'b0; addr = 3'd7;
    repeat (4) @(negedge clk);
    do_read("R8 phase held", 8'h14);

    // R3: sleep does not disturb scratch
    @(negedge clk); swap_en = 1'b0; sleep = 1'b1;
    repeat (6) @(negedge clk);
    do_read("R3 sleep keep", 8'h5A);
    sleep = 1'b0;

    // R2: mid-run reset restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    check("R2 scratch FF", rdata, 8'hFF);
    check("R2 dir cleared", {7'd0, dir_pol}, 8'h00);
    swap_en = 1'b1; rx_level = 7'd5; tx_level = 7'd9; #1;
    check("R2 mode cleared selects rx", rdata, 8'h05);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule